// File: doc/BRIEF.md
# Sample-Disagreement Loss-of-Signal Monitor

This block watches the per-bit decisions of a three-point bang-bang phase detector and raises a loss-of-signal alarm. Each valid bit carries three samples: the centre of the current bit, a point near the following edge, and the centre of the next bit. The two centre samples may agree while the edge sample disagrees with both. In that case no edge took place, yet the edge sample took a wrong value, so the bit is counted as an error. The count is formed over fixed windows of valid bits and compared with two thresholds far apart. The alarm rises on a high count and falls only on a very low one. The test looks at sample agreement alone, so it works for any payload and any framing.

A second path looks for lack of activity. A run of valid bits with no edge between the two centre samples raises the alarm at once, without waiting for the window to close. The alarm is a single register that is set by reset. Apart from that immediate path, it changes only when a window has been evaluated.

Top module: `los_monitor`

## Requirements
- R1: An error event is a valid bit with A equal to B and T different from A, for either polarity. A bit with A different from B (whatever T is) and a bit with A, T and B all equal are not error events.
- R2: After reset the alarm output is 1.
- R3: When a window of WIN_BITS valid bits closes with an error count strictly greater than RAISE_CNT, the alarm is 1 on the second clock edge after the last bit of the window.
- R4: When a window closes with an error count strictly less than CLEAR_CNT and the activity check is not tripped, the alarm is 0 on the second clock edge after the last bit of the window.
- R5: When a window closes with a count from CLEAR_CNT to RAISE_CNT inclusive, the alarm keeps its previous value. This holds in both states, and also when the count equals either threshold.
- R6: Between window boundaries the alarm does not change, even when the errors seen so far already exceed RAISE_CNT. The activity check is the only exception.
- R7: A run of QUIET_BITS consecutive valid bits with A equal to B sets the alarm within two clock edges, in the middle of a window. A valid bit with A different from B restarts the run.
- R8: While the activity check is tripped, a window result below CLEAR_CNT does not clear the alarm.
- R9: Cycles with the valid strobe low count neither as bits of the window nor as error events, and they do not extend or break the run of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | High when the three samples of this cycle belong to one bit |
| smp_a | input | 1 | Centre sample of the current bit |
| smp_t | input | 1 | Sample taken near the expected edge |
| smp_b | input | 1 | Centre sample of the following bit |
| los_alarm | output | 1 | Registered loss-of-signal alarm, 1 = signal lost |

## Verification
A bit counter that is off by even one moves every window boundary. The next threshold decision then lands a bit early or late, and whole windows later the alarm is seen at the wrong bit position. A tally that lumps edge bits or flat bits in with the errors shows up after one window: a stream with no errors fails to clear the alarm. An activity run that is not restarted by an edge, or that counts invalid cycles, raises the alarm in mid-window, two edges after the run would have been reached. A lost hysteresis decision shows at the first window whose count lies between the two limits.

// File: rtl/los_pkg.sv
// Shared types for the loss-of-signal monitor.
// Assumes: one classification per clock cycle.
package los_pkg;

    // Kind of bit seen by the phase-detector sampler in one cycle.
    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,   // no valid sample this cycle
        CLS_EDGE = 2'b01,   // centre samples differ: a data edge
        CLS_FLAT = 2'b10,   // all three samples agree: no edge
        CLS_SLIP = 2'b11    // centre samples agree, edge sample disagrees
    } bit_cls_e;

endpackage

// File: rtl/los_bit_classify.sv
// Sorts each sampled bit into edge, flat, slip or none.
// Assumes: the samples are stable in the cycle that smp_vld is high.
module los_bit_classify
    import los_pkg::*;
(
    input  logic     vld,
    input  logic     a,
    input  logic     t,
    input  logic     b,
    output bit_cls_e cls
);

    // Decode the three samples; the edge decision takes priority over T.
    always_comb begin
        if (!vld) begin
            cls = CLS_NONE;
        end else if (a != b) begin
            cls = CLS_EDGE;
        end else if (t != a) begin
            cls = CLS_SLIP;
        end else begin
            cls = CLS_FLAT;
        end
    end

endmodule

// File: rtl/los_win_tally.sv
// Counts error bits over fixed windows of valid bits and reports the
// total of each window with a one-cycle strobe.
// Assumes: WIN_BITS >= 2; CNT_W can hold WIN_BITS.
module los_win_tally
    import los_pkg::*;
#(
    parameter int WIN_BITS = 4096,
    parameter int CNT_W    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bit_cls_e         cls,
    output logic             win_done,
    output logic [CNT_W-1:0] win_errs
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIN_BITS - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] err_next;
    logic             bit_in;
    logic             err_in;

    assign bit_in   = (cls != CLS_NONE);
    assign err_in   = (cls == CLS_SLIP);
    assign err_next = err_cnt + {{(CNT_W-1){1'b0}}, err_in};

    // Advance the window on each valid bit; close and report at the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            err_cnt  <= '0;
            win_done <= 1'b0;
            win_errs <= '0;
        end else begin
            win_done <= 1'b0;
            if (bit_in) begin
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    err_cnt  <= '0;
                    win_done <= 1'b1;
                    win_errs <= err_next;
                end else begin
                    bit_cnt  <= bit_cnt + 1'b1;
                    err_cnt  <= err_next;
                end
            end
        end
    end

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_NONE) |=> ($stable(bit_cnt) && $stable(err_cnt)));

    // R1
    err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= bit_cnt);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

endmodule

// File: rtl/los_quiet_watch.sv
// Flags lack of activity: QUIET_BITS valid bits in a row with no edge
// between the centre samples.
// Assumes: QUIET_BITS >= 1; the run counter saturates at the limit.
module los_quiet_watch
    import los_pkg::*;
#(
    parameter int QUIET_BITS = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bit_cls_e cls,
    output logic     quiet
);

    localparam int               RUN_W   = $clog2(QUIET_BITS + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(QUIET_BITS);

    logic [RUN_W-1:0] run_cnt;

    // Restart on an edge, extend on a flat or slip bit, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (cls == CLS_EDGE) begin
            run_cnt <= '0;
        end else if ((cls != CLS_NONE) && (run_cnt != RUN_MAX)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign quiet = (run_cnt == RUN_MAX);

    // R7
    edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_EDGE) |=> (run_cnt == '0));

    // R7
    run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_MAX);

endmodule

// File: rtl/los_monitor.sv
// Loss-of-signal monitor: combines the windowed error count (with
// hysteresis) and the activity check into one registered alarm.
// Assumes: CLEAR_CNT <= RAISE_CNT < WIN_BITS; alarm is set by reset.
module los_monitor
    import los_pkg::*;
#(
    parameter int WIN_BITS   = 4096,
    parameter int RAISE_CNT  = 204,
    parameter int CLEAR_CNT  = 4,
    parameter int QUIET_BITS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic smp_a,
    input  logic smp_t,
    input  logic smp_b,
    output logic los_alarm
);

    localparam int               CNT_W   = $clog2(WIN_BITS + 1);
    localparam logic [CNT_W-1:0] RAISE_V = CNT_W'(RAISE_CNT);
    localparam logic [CNT_W-1:0] CLEAR_V = CNT_W'(CLEAR_CNT);

    bit_cls_e         cls;
    logic             win_done;
    logic [CNT_W-1:0] win_errs;
    logic             quiet;
    logic             alarm_q;

    los_bit_classify u_cls (
        .vld (smp_vld),
        .a   (smp_a),
        .t   (smp_t),
        .b   (smp_b),
        .cls (cls)
    );

    los_win_tally #(
        .WIN_BITS (WIN_BITS),
        .CNT_W    (CNT_W)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .win_done (win_done),
        .win_errs (win_errs)
    );

    los_quiet_watch #(
        .QUIET_BITS (QUIET_BITS)
    ) u_quiet (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .quiet (quiet)
    );

    // Alarm register: activity loss first, then the window decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b1;
        end else if (quiet) begin
            alarm_q <= 1'b1;
        end else if (win_done) begin
            if (win_errs > RAISE_V) begin
                alarm_q <= 1'b1;
            end else if (win_errs < CLEAR_V) begin
                alarm_q <= 1'b0;
            end
        end
    end

    assign los_alarm = alarm_q;

    // R6
    alarm_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q != $past(alarm_q)) |-> ($past(win_done) || $past(quiet)));

    // R3
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_done) && ($past(win_errs) > RAISE_V)) |-> alarm_q);

    // R4
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_done) && ($past(win_errs) < CLEAR_V) && !$past(quiet))
        |-> !alarm_q);

    // R8
    quiet_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(quiet) |-> alarm_q);

endmodule

// File: tb/sim_los_monitor.sv
// Directed bench for los_monitor with a short window for run time.
module sim_los_monitor;

    localparam int W     = 200;
    localparam int RAISE = 10;
    localparam int CLEAR = 2;
    localparam int QUIET = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic smp_a = 1'b0;
    logic smp_t = 1'b0;
    logic smp_b = 1'b0;
    logic los_alarm;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    los_monitor #(
        .WIN_BITS   (W),
        .RAISE_CNT  (RAISE),
        .CLEAR_CNT  (CLEAR),
        .QUIET_BITS (QUIET)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp_a     (smp_a),
        .smp_t     (smp_t),
        .smp_b     (smp_b),
        .los_alarm (los_alarm)
    );

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (los_alarm !== exp) begin
            n_fail++;
            $display("FAIL %s: los_alarm=%0b expected %0b", tag, los_alarm, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input logic a, input logic t, input logic b);
        @(negedge clk);
        smp_vld = v;
        smp_a   = a;
        smp_t   = t;
        smp_b   = b;
    endtask

    // Three idle cycles: the alarm is settled two edges after the last bit.
    task automatic settle();
        repeat (3) drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Even slots carry slips (then optional flats); odd slots are edges.
    task automatic send_mix(input int n_bits, input int n_slip, input logic pol, input logic flats);
        int left;
        left = n_slip;
        for (int i = 0; i < n_bits; i++) begin
            logic e;
            logic tv;
            e  = ((i / 2) % 2) == 1;
            tv = ((i / 4) % 2) == 1;
            if ((i % 2 == 0) && (left > 0)) begin
                drive_bit(1'b1, pol, ~pol, pol);
                left--;
            end else if ((i % 4 == 2) && flats) begin
                drive_bit(1'b1, tv, tv, tv);
            end else begin
                drive_bit(1'b1, e, tv, ~e);
            end
        end
    endtask

    task automatic send_flat(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset_hold();
        do_reset();
        settle();
        chk("R2 alarm after reset", 1'b1);
        send_mix(W, 5, 1'b0, 1'b0);
        settle();
        chk("R5 mid-band window keeps alarm set", 1'b1);
    endtask

    task automatic t_levels();
        do_reset();
        send_mix(W, 0, 1'b0, 1'b0);
        settle();
        chk("R4 clean window clears alarm", 1'b0);
        send_mix(W, RAISE, 1'b0, 1'b0);
        settle();
        chk("R5 count equal to raise limit holds clear", 1'b0);
        send_mix(W, RAISE + 1, 1'b0, 1'b0);
        settle();
        chk("R3 count above raise limit sets alarm", 1'b1);
        send_mix(W, CLEAR, 1'b0, 1'b0);
        settle();
        chk("R5 count equal to clear limit holds set", 1'b1);
        send_mix(W, CLEAR - 1, 1'b0, 1'b0);
        settle();
        chk("R4 count below clear limit clears alarm", 1'b0);
    endtask

    task automatic t_classify();
        do_reset();
        send_mix(W, 0, 1'b0, 1'b0);
        settle();
        send_mix(W, RAISE + 1, 1'b1, 1'b1);
        settle();
        chk("R1 high-polarity slips are counted", 1'b1);
        send_mix(W, 0, 1'b0, 1'b1);
        settle();
        chk("R1 edges and flat bits are not counted", 1'b0);
    endtask

    task automatic t_mid_window();
        do_reset();
        send_mix(W, 0, 1'b0, 1'b0);
        settle();
        send_mix(50, 25, 1'b0, 1'b0);
        settle();
        chk("R6 no change before window closes", 1'b0);
        send_mix(W - 50, 0, 1'b0, 1'b0);
        settle();
        chk("R6 change at window close", 1'b1);
    endtask

    task automatic t_quiet();
        do_reset();
        send_mix(W, 0, 1'b0, 1'b0);
        settle();
        send_flat(QUIET);
        settle();
        chk("R7 quiet run sets alarm mid-window", 1'b1);
        do_reset();
        send_mix(W, 0, 1'b0, 1'b0);
        settle();
        send_flat(QUIET - 1);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b1);
        send_flat(QUIET - 1);
        settle();
        chk("R7 edge restarts quiet run", 1'b0);
        send_flat(1);
        settle();
        chk("R7 run reaches limit exactly", 1'b1);
    endtask

    task automatic t_quiet_priority();
        do_reset();
        send_mix(W, 0, 1'b0, 1'b0);
        settle();
        send_mix(W - QUIET, 0, 1'b0, 1'b0);
        send_flat(QUIET);
        settle();
        chk("R8 quiet beats clean window result", 1'b1);
        send_mix(W, 0, 1'b0, 1'b0);
        settle();
        chk("R8 clean active window clears after quiet ends", 1'b0);
    endtask

    task automatic t_invalid();
        do_reset();
        send_mix(W / 2, 0, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) drive_bit(1'b0, 1'b0, 1'b1, 1'b0);
        settle();
        chk("R9 invalid cycles leave alarm set", 1'b1);
        send_mix(W / 2, 0, 1'b0, 1'b0);
        settle();
        chk("R9 invalid cycles neither counted nor quiet", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_hold();
        t_levels();
        t_classify();
        t_mid_window();
        t_quiet();
        t_quiet_priority();
        t_invalid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule